// File: doc/BRIEF.md
# FNV hash integrity checker

This block computes a Fowler-Noll-Vo style hash over a block of constant data, such as program code or a configuration table, streamed in one byte per clock cycle. A start pulse loads the hash register with a width-dependent offset basis. Each accepted byte then updates the hash in two steps: the hash is multiplied by a fixed prime, and the byte is XOR-ed into the low bits of the product. The product is truncated to the hash width.

When the byte flagged as last has been taken, the block compares the finished hash with a reference value supplied on a port. It pulses a done flag and raises exactly one of two verdict flags, match or mismatch. A mismatch means that the constant data is corrupted. The verdict stays up until the next start pulse, so supervising logic can sample it at its leisure. The hash width is a parameter. The 32-bit width is the one verified.

Top module: `fnv_hash_checker`

## Requirements
- R1: After reset, done_o, match_o and mismatch_o are 0 and hash_o equals the offset basis, which is 0x811C9DC5 for the 32-bit width.
- R2: A start_i pulse loads the hash register with the offset basis and clears done_o, match_o and mismatch_o. The result is visible in the cycle after the pulse.
- R3: For each accepted byte, the new hash is (hash × prime) mod 2^W, XOR-ed with the byte zero-extended to W bits. The prime is 0x01000193 for W = 32, and the multiply comes before the XOR.
- R4: done_o is high for exactly one cycle, in the cycle right after the cycle in which the byte with in_last_i = 1 was accepted. In that cycle hash_o holds the final hash.
- R5: In the cycle where done_o is high, match_o = 1 if the final hash equals expected_i as sampled with the last byte; otherwise mismatch_o = 1.
- R6: match_o and mismatch_o are never both 1. Once set, they hold their values until the next start_i pulse.
- R7: A start_i pulse during a computation discards the partial hash and restarts from the offset basis. A byte presented in the same cycle as start_i is discarded.
- R8: Bytes presented while no computation is running (after reset, or after the last byte) are ignored: hash_o and the verdict flags do not change.
- R9: Cycles with in_valid_i = 0 inside a block leave the hash unchanged, so gaps in the stream do not alter the result.
- R10: A block of a single byte (start_i, then one byte with in_last_i = 1) yields the hash of that one byte and a verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new hash computation |
| in_valid_i | input | 1 | A data byte is present this cycle |
| in_last_i | input | 1 | The present byte ends the block |
| in_byte_i | input | 8 | Data byte |
| expected_i | input | HASH_W | Reference hash for the block |
| done_o | output | 1 | One-cycle pulse: computation finished |
| match_o | output | 1 | Final hash equalled the reference |
| mismatch_o | output | 1 | Final hash differed from the reference |
| hash_o | output | HASH_W | Current or final hash value |

## Verification
The hardest case to reach from the ports is a restart. A start pulse must arrive while a block is half-hashed, and a stray valid byte must arrive in the same cycle. Only the correct result can show that the partial state and the stray byte were both dropped. The driver first abandons a block after a few bytes. It then raises start together with a valid byte, and the scoreboard expects the hash of the restarted block alone. Idle bytes sent after a verdict, and valid-low gaps inside a long block, show whether the block accepts bytes at the wrong moments.

// File: rtl/fnv_pkg.sv
package fnv_pkg;
  localparam int BYTE_W = 8;
  localparam int MAX_W  = 1024;

  // Offset basis per hash width; widths without a table entry use the 32-bit value
  function automatic logic [MAX_W-1:0] basis_for(input int w);
    logic [MAX_W-1:0] v;
    v = '0;
    if (w == 64) v[63:0] = 64'hCBF2_9CE4_8422_2325;
    else         v[31:0] = 32'h811C_9DC5;
    return v;
  endfunction

  // Multiplier prime per hash width
  function automatic logic [MAX_W-1:0] prime_for(input int w);
    logic [MAX_W-1:0] v;
    v = '0;
    if (w == 64) v[63:0] = 64'h0000_0100_0000_01B3;
    else         v[31:0] = 32'h0100_0193;
    return v;
  endfunction
endpackage

// File: rtl/fnv_step.sv
module fnv_step #(
  parameter int HASH_W = 32,
  parameter logic [HASH_W-1:0] PRIME = '0
) (
  input  logic [HASH_W-1:0]          state_i,
  input  logic [fnv_pkg::BYTE_W-1:0] byte_i,
  output logic [HASH_W-1:0]          next_o
);
  localparam int PAD_W = HASH_W - fnv_pkg::BYTE_W;

  logic [HASH_W-1:0] product;

  always_comb begin
    product = state_i * PRIME;
    next_o  = product ^ {{PAD_W{1'b0}}, byte_i};
  end
endmodule

// File: rtl/fnv_core.sv
module fnv_core #(
  parameter int HASH_W = 32,
  parameter logic [HASH_W-1:0] BASIS = '0,
  parameter logic [HASH_W-1:0] PRIME = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic                       valid_i,
  input  logic                       last_i,
  input  logic [fnv_pkg::BYTE_W-1:0] byte_i,
  output logic [HASH_W-1:0]          hash_q,
  output logic [HASH_W-1:0]          next_o,
  output logic                       fin_o,
  output logic                       busy_o
);
  logic busy_q;
  logic take;

  fnv_step #(.HASH_W(HASH_W), .PRIME(PRIME)) u_step (
    .state_i (hash_q),
    .byte_i  (byte_i),
    .next_o  (next_o)
  );

  assign take   = valid_i && busy_q && !start_i;
  assign fin_o  = take && last_i;
  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hash_q <= BASIS;
      busy_q <= 1'b0;
    end else if (start_i) begin
      hash_q <= BASIS;
      busy_q <= 1'b1;
    end else if (take) begin
      hash_q <= next_o;
      if (last_i) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fnv_compare.sv
module fnv_compare #(
  parameter int HASH_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              fin_i,
  input  logic [HASH_W-1:0] final_i,
  input  logic [HASH_W-1:0] expected_i,
  output logic              done_o,
  output logic              match_o,
  output logic              mismatch_o
);
  logic equal;
  assign equal = (final_i == expected_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o     <= 1'b0;
      match_o    <= 1'b0;
      mismatch_o <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (start_i) begin
        match_o    <= 1'b0;
        mismatch_o <= 1'b0;
      end else if (fin_i) begin
        match_o    <= equal;
        mismatch_o <= !equal;
      end
    end
  end
endmodule

// File: rtl/fnv_hash_checker.sv
module fnv_hash_checker #(
  parameter int HASH_W = 32,
  parameter logic [HASH_W-1:0] OFFSET_BASIS = HASH_W'(fnv_pkg::basis_for(HASH_W)),
  parameter logic [HASH_W-1:0] PRIME        = HASH_W'(fnv_pkg::prime_for(HASH_W))
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic                       in_valid_i,
  input  logic                       in_last_i,
  input  logic [fnv_pkg::BYTE_W-1:0] in_byte_i,
  input  logic [HASH_W-1:0]          expected_i,
  output logic                       done_o,
  output logic                       match_o,
  output logic                       mismatch_o,
  output logic [HASH_W-1:0]          hash_o
);
  logic [HASH_W-1:0] next_hash;
  logic              fin;
  logic              core_busy;

  fnv_core #(.HASH_W(HASH_W), .BASIS(OFFSET_BASIS), .PRIME(PRIME)) u_core (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .valid_i (in_valid_i),
    .last_i  (in_last_i),
    .byte_i  (in_byte_i),
    .hash_q  (hash_o),
    .next_o  (next_hash),
    .fin_o   (fin),
    .busy_o  (core_busy)
  );

  fnv_compare #(.HASH_W(HASH_W)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .fin_i      (fin),
    .final_i    (next_hash),
    .expected_i (expected_i),
    .done_o     (done_o),
    .match_o    (match_o),
    .mismatch_o (mismatch_o)
  );
endmodule

// File: rtl/fnv_hash_checker_sva.sv
module fnv_hash_checker_sva #(
  parameter int HASH_W = 32,
  parameter logic [HASH_W-1:0] BASIS = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              in_valid_i,
  input logic              done_o,
  input logic              match_o,
  input logic              mismatch_o,
  input logic [HASH_W-1:0] hash_o,
  input logic              busy
);
  // R2: start loads the basis and clears all flags
  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (hash_o == BASIS) && !done_o && !match_o && !mismatch_o);

  // R4: done lasts a single cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: a finished computation always carries exactly one verdict
  p_verdict_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (match_o ^ mismatch_o));

  // R6: the two verdicts never coexist
  p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(match_o && mismatch_o));

  // R6: verdicts move only on done or start
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> (done_o || ($stable(match_o) && $stable(mismatch_o))));

  // R8: idle bytes do not touch the hash
  p_idle_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_i) |=> $stable(hash_o));

  // R9: valid-low cycles leave the hash alone
  p_gap_r9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid_i && !start_i) |=> $stable(hash_o));
endmodule

bind fnv_hash_checker fnv_hash_checker_sva #(.HASH_W(HASH_W), .BASIS(OFFSET_BASIS)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .in_valid_i (in_valid_i),
  .done_o     (done_o),
  .match_o    (match_o),
  .mismatch_o (mismatch_o),
  .hash_o     (hash_o),
  .busy       (core_busy)
);

// File: tb/sim_fnv_hash_checker.sv
`timescale 1ns/1ps
module sim_fnv_hash_checker;
  localparam logic [31:0] BASIS_V = 32'h811C_9DC5;
  localparam logic [31:0] PRIME_V = 32'h0100_0193;

  typedef logic [7:0] bq_t[$];

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_last_i = 1'b0;
  logic [7:0]  in_byte_i = 8'h00;
  logic [31:0] expected_i = 32'h0;
  logic        done_o, match_o, mismatch_o;
  logic [31:0] hash_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] exp_hash_q[$];
  bit          exp_ok_q[$];

  always #2 clk = ~clk;

  fnv_hash_checker #(.HASH_W(32)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .in_valid_i(in_valid_i),
    .in_last_i(in_last_i), .in_byte_i(in_byte_i), .expected_i(expected_i),
    .done_o(done_o), .match_o(match_o), .mismatch_o(mismatch_o), .hash_o(hash_o)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_hash(input bq_t d);
    logic [31:0] h;
    h = BASIS_V;
    foreach (d[i]) h = (h * PRIME_V) ^ {24'h0, d[i]};
    return h;
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Driver: pushes expectations, then streams one block
  task automatic send_block(input bq_t d, input bit gaps, input bit corrupt, input int n_abandon);
    logic [31:0] h;
    h = ref_hash(d);
    exp_hash_q.push_back(h);
    exp_ok_q.push_back(!corrupt);
    @(negedge clk);
    if (n_abandon > 0) begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < n_abandon; k++) begin
        in_valid_i = 1'b1; in_byte_i = 8'(k + 16); in_last_i = 1'b0;
        @(negedge clk);
      end
      in_valid_i = 1'b1; in_byte_i = 8'hFF; in_last_i = 1'b0; // R7 stray byte with start
    end
    start_i = 1'b1;
    expected_i = corrupt ? (h ^ 32'h0000_0100) : h;
    @(negedge clk);
    start_i = 1'b0; in_valid_i = 1'b0;
    chk("R2 hash after start", hash_o, BASIS_V);
    chk("R2 match cleared", {31'b0, match_o}, 32'd0);
    chk("R2 mismatch cleared", {31'b0, mismatch_o}, 32'd0);
    for (int i = 0; i < d.size(); i++) begin
      if (gaps && (i % 3 == 1)) begin
        in_valid_i = 1'b0; in_byte_i = 8'hA5;
        @(negedge clk);
      end
      in_valid_i = 1'b1; in_byte_i = d[i]; in_last_i = (i == d.size() - 1);
      @(negedge clk);
    end
    in_valid_i = 1'b0; in_last_i = 1'b0;
    #1;
    chk("R4 done seen right after last byte", 32'(exp_hash_q.size()), 32'd0);
    @(negedge clk);
    chk("R4 done is one cycle", {31'b0, done_o}, 32'd0);
  endtask

  // Monitor: pops expectations when done pulses
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (exp_hash_q.size() == 0) begin
        chk("R4 unexpected done", 32'd1, 32'd0);
      end else begin
        logic [31:0] eh;
        bit ok;
        eh = exp_hash_q.pop_front();
        ok = exp_ok_q.pop_front();
        chk("R3 final hash", hash_o, eh);
        chk("R5 match flag", {31'b0, match_o}, {31'b0, ok});
        chk("R5 mismatch flag", {31'b0, mismatch_o}, {31'b0, !ok});
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bq_t blk;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done after reset", {31'b0, done_o}, 32'd0);
    chk("R1 match after reset", {31'b0, match_o}, 32'd0);
    chk("R1 mismatch after reset", {31'b0, mismatch_o}, 32'd0);
    chk("R1 hash after reset", hash_o, BASIS_V);

    // R8: bytes before any start are ignored
    in_valid_i = 1'b1; in_byte_i = 8'h3C; in_last_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0; in_last_i = 1'b0;
    chk("R8 idle byte after reset", hash_o, BASIS_V);
    chk("R8 no done when idle", {31'b0, done_o}, 32'd0);

    // R10: single-byte block
    blk = {8'h61};
    send_block(blk, 1'b0, 1'b0, 0);

    // R3 R5: short block, matching reference
    blk = {8'h68, 8'h65, 8'h6C, 8'h6C, 8'h6F};
    send_block(blk, 1'b0, 1'b0, 0);

    // R9: long block with gaps
    blk = {};
    for (int i = 0; i < 64; i++) blk.push_back(8'(i * 37 + 5));
    send_block(blk, 1'b1, 1'b0, 0);

    // R5: corrupted reference gives mismatch
    blk = {8'h00, 8'hFF, 8'h55, 8'hAA};
    send_block(blk, 1'b0, 1'b1, 0);

    // R6 R8: verdict and hash hold while idle bytes arrive
    held = hash_o;
    for (int k = 0; k < 4; k++) begin
      in_valid_i = 1'b1; in_byte_i = 8'(k * 9 + 1); in_last_i = (k == 3);
      @(negedge clk);
      chk("R8 hash ignores idle byte", hash_o, held);
      chk("R6 mismatch holds", {31'b0, mismatch_o}, 32'd1);
      chk("R6 match stays low", {31'b0, match_o}, 32'd0);
    end
    in_valid_i = 1'b0; in_last_i = 1'b0;

    // R7: abandon a partial block, restart with a stray byte present
    blk = {8'h12, 8'h34, 8'h56};
    send_block(blk, 1'b0, 1'b0, 3);

    // R6: verdict after a match holds too
    repeat (3) @(negedge clk);
    chk("R6 match holds", {31'b0, match_o}, 32'd1);

    finished = 1;
    summary();
    $finish;
  end
endmodule